// File: doc/BRIEF.md
# Prioritized Interrupt Vector Register

This block gathers the one-cycle event pulses of a serial-bus controller into a set of sticky pending flags. It gates those flags with a software enable mask and drives one level interrupt line. It also encodes the most urgent enabled pending event as a small code in a vector register. Seven events are tracked: arbitration lost, no-acknowledge, register-access ready, receive data ready, transmit data ready, stop detected and addressed as slave.

Software reaches the block over a simple 16-bit register port, one access per cycle, with combinational read data. The mask register sits at offset 0x04, the status register at 0x08 and the vector register at 0x28. Reading the vector register returns the winning code and acknowledges that event. An interrupt handler can therefore loop on that one register until it reads 0. The status register also shows two live levels from the bus engine: receive shift full and bus busy.

Top module: `ivr_ctrl`

## Requirements
- R1: After reset the mask is 0, no event is pending, the vector reads 0 and `irq` is low.
- R2: The mask register at offset 0x04 is read/write in bits 6:0 and reads 0 in bits 15:7. Bit i enables event i. The bits are: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: A pulse on `evt_pulse[i]` sets pending flag i, whatever the mask. Flag i reads as bit i of the status register at 0x08 from the cycle after the pulse, and a masked flag stays set.
- R4: Status bit 11 shows `eng_rx_full` and status bit 12 shows `eng_busy` in the same cycle. Status bits 7 to 10 and 13 to 15 read 0, and writes to them have no effect.
- R5: Writing 1 to status bit 2 (access ready) or bit 5 (stop detected) clears that flag. Writing 1 to status bits 0, 1, 3, 4 or 6 has no effect.
- R6: The vector register at 0x28 reads i+1 for the lowest-numbered event i that is both pending and enabled, so arbitration lost has the highest priority. It reads 0 when no such event exists.
- R7: A read of the vector register that returns a nonzero code clears that event's pending flag from the next cycle on. Repeated reads step through the enabled events up to 0. A read that returns 0 clears nothing, and masked pending flags are left alone.
- R8: `irq` is high while any event is both pending and enabled. It falls in the cycle after the last such event is cleared or masked.
- R9: A pulse that arrives in the same cycle as a clear of the same flag, by write-1 or by vector read, leaves the flag set.
- R10: Offsets other than 0x04, 0x08 and 0x28 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read (side effect on vector) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| evt_pulse | input | 7 | One-cycle event pulses from the bus engine, bit order as R2 |
| eng_busy | input | 1 | Bus busy level from the engine |
| eng_rx_full | input | 1 | Receive shift full level from the engine |
| irq | output | 1 | Level interrupt request |

## Verification
The encoder is driven with all seven events pending and fully enabled, which must drain in code order 1 to 7. It is also driven with sparse pending sets such as events 4 and 6 only, and with a mask that hides the top-priority pending event; these separate true priority from simple position counting and show that the mask reaches the encoder. A fully masked pending set tells vector gating apart from pending storage. Same-cycle pulse-and-clear patterns, both by write-1 and by vector read, show whether set takes precedence over clear.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int unsigned EVT_N_DEF   = 7;
    localparam int unsigned DATA_W_DEF  = 16;
    localparam int unsigned ADDR_W_DEF  = 8;

    localparam int unsigned EV_ARB_LOST = 0;
    localparam int unsigned EV_NACK     = 1;
    localparam int unsigned EV_ACC_RDY  = 2;
    localparam int unsigned EV_RX_RDY   = 3;
    localparam int unsigned EV_TX_RDY   = 4;
    localparam int unsigned EV_STOP     = 5;
    localparam int unsigned EV_SLV_ADDR = 6;

    typedef enum logic [2:0] {
        VC_NONE     = 3'd0,
        VC_ARB_LOST = 3'd1,
        VC_NACK     = 3'd2,
        VC_ACC_RDY  = 3'd3,
        VC_RX_RDY   = 3'd4,
        VC_TX_RDY   = 3'd5,
        VC_STOP     = 3'd6,
        VC_SLV_ADDR = 3'd7
    } vec_code_e;

    typedef struct packed {
        logic mask_sel;
        logic stat_sel;
        logic vec_sel;
        logic mask_wr;
        logic stat_wr;
        logic vec_rd;
    } acc_dec_t;

    // event index i maps to vector code i+1
    function automatic int unsigned idx_to_code(input int unsigned idx);
        return idx + 1;
    endfunction

endpackage

// File: rtl/ivr_decode.sv
module ivr_decode
    import ivr_pkg::*;
#(
    parameter int unsigned ADDR_W   = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h04,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h08,
    parameter logic [ADDR_W-1:0] VEC_OFS  = 'h28
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output acc_dec_t          dec
);

    always_comb begin
        dec          = '0;
        dec.mask_sel = (addr == MASK_OFS);
        dec.stat_sel = (addr == STAT_OFS);
        dec.vec_sel  = (addr == VEC_OFS);
        dec.mask_wr  = dec.mask_sel & wr;
        dec.stat_wr  = dec.stat_sel & wr;
        dec.vec_rd   = dec.vec_sel & rd;
    end

endmodule

// File: rtl/ivr_pending.sv
module ivr_pending #(
    parameter int unsigned NUM_EVT = 7,
    parameter logic [NUM_EVT-1:0] W1C_MASK = 7'h24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               w1c_en,
    input  logic [NUM_EVT-1:0] w1c_bits,
    input  logic               ack_en,
    input  logic [NUM_EVT-1:0] ack_onehot,
    output logic [NUM_EVT-1:0] pend
);

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
        logic clr;
        assign clr = (w1c_en & W1C_MASK[g] & w1c_bits[g]) | (ack_en & ack_onehot[g]);

        always_ff @(posedge clk) begin
            if (rst)
                pend[g] <= 1'b0;
            else if (evt[g])
                pend[g] <= 1'b1;   // set beats a same-cycle clear
            else if (clr)
                pend[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/ivr_prio.sv
module ivr_prio #(
    parameter int unsigned NUM_EVT = 7,
    localparam int unsigned CODE_W = $clog2(NUM_EVT + 1)
) (
    input  logic [NUM_EVT-1:0] req,
    output logic [CODE_W-1:0]  code,
    output logic [NUM_EVT-1:0] grant
);

    // scan from lowest to highest priority so the lowest index is kept
    always_comb begin
        code  = '0;
        grant = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (req[i]) begin
                code  = CODE_W'(i + 1);
                grant = '0;
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ivr_ctrl.sv
module ivr_ctrl
    import ivr_pkg::*;
#(
    parameter int unsigned NUM_EVT  = EVT_N_DEF,
    parameter int unsigned DATA_W   = DATA_W_DEF,
    parameter int unsigned ADDR_W   = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] MASK_OFS = 'h04,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h08,
    parameter logic [ADDR_W-1:0] VEC_OFS  = 'h28,
    parameter int unsigned RXF_BIT  = 11,
    parameter int unsigned BUSY_BIT = 12,
    parameter logic [NUM_EVT-1:0] W1C_MASK = 7'h24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               eng_busy,
    input  logic               eng_rx_full,
    output logic               irq
);

    localparam int unsigned CODE_W = $clog2(NUM_EVT + 1);

    acc_dec_t           dec;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] pend;
    logic [NUM_EVT-1:0] live;
    logic [NUM_EVT-1:0] grant;
    logic [CODE_W-1:0]  code;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_EVT];

    ivr_decode #(
        .ADDR_W   (ADDR_W),
        .MASK_OFS (MASK_OFS),
        .STAT_OFS (STAT_OFS),
        .VEC_OFS  (VEC_OFS)
    ) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .dec  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (dec.mask_wr)
            mask_q <= bus_wdata[NUM_EVT-1:0];
    end

    assign live = pend & mask_q;

    ivr_prio #(.NUM_EVT(NUM_EVT)) u_prio (
        .req   (live),
        .code  (code),
        .grant (grant)
    );

    ivr_pending #(
        .NUM_EVT  (NUM_EVT),
        .W1C_MASK (W1C_MASK)
    ) u_pend (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt_pulse),
        .w1c_en     (dec.stat_wr),
        .w1c_bits   (bus_wdata[NUM_EVT-1:0]),
        .ack_en     (dec.vec_rd),
        .ack_onehot (grant),
        .pend       (pend)
    );

    assign irq = |live;

    always_comb begin
        bus_rdata = '0;
        if (dec.mask_sel) begin
            bus_rdata[NUM_EVT-1:0] = mask_q;
        end else if (dec.stat_sel) begin
            bus_rdata[NUM_EVT-1:0] = pend;
            bus_rdata[RXF_BIT]     = eng_rx_full;
            bus_rdata[BUSY_BIT]    = eng_busy;
        end else if (dec.vec_sel) begin
            bus_rdata[CODE_W-1:0]  = code;
        end
    end

endmodule

// File: rtl/ivr_ctrl_chk.sv
module ivr_ctrl_chk #(
    parameter int unsigned NUM_EVT = 7,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h08,
    parameter logic [ADDR_W-1:0] VEC_OFS  = 'h28
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic               irq,
    input logic [NUM_EVT-1:0] pend,
    input logic [NUM_EVT-1:0] mask_q
);

    p_evt_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=> ((pend & $past(evt_pulse)) == $past(evt_pulse)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse == '0 && !bus_wr && !bus_rd) |=> $stable(pend));

    p_w1c_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == STAT_OFS && bus_wdata[5] && !evt_pulse[5]) |=> !pend[5]);

    p_vec_range_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == VEC_OFS) |-> (bus_rdata <= DATA_W'(NUM_EVT)));

    p_vec_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == VEC_OFS && (pend & mask_q) == '0) |-> (bus_rdata == '0));

    p_vec_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == VEC_OFS && bus_rdata != '0 && evt_pulse == '0 && !bus_wr)
        |=> ($countones(pend) == $past($countones(pend)) - 1));

    p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(bus_wr || bus_rd));

endmodule

bind ivr_ctrl ivr_ctrl_chk #(
    .NUM_EVT  (NUM_EVT),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .VEC_OFS  (VEC_OFS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_pulse (evt_pulse),
    .irq       (irq),
    .pend      (pend),
    .mask_q    (mask_q)
);

// File: tb/tb_ivr_ctrl.sv
module tb_ivr_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_MASK = 8'h04;
    localparam logic [7:0] A_STAT = 8'h08;
    localparam logic [7:0] A_VEC  = 8'h28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [6:0]  evt_pulse = '0;
    logic        eng_busy = 1'b0;
    logic        eng_rx_full = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ivr_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .evt_pulse   (evt_pulse),
        .eng_busy    (eng_busy),
        .eng_rx_full (eng_rx_full),
        .irq         (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    // empties every pending flag through the vector register
    task automatic flush();
        logic [15:0] d;
        reg_write(A_MASK, 16'h007F);
        for (int k = 0; k < 8; k++) reg_read(A_VEC, d);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 irq", {15'd0, irq}, 16'h0001 & 16'h0000);
        reg_read(A_MASK, d); check("R1 mask", d, 16'h0000);
        reg_read(A_STAT, d); check("R1 status", d, 16'h0000);
        reg_read(A_VEC, d);  check("R1 vector", d, 16'h0000);
    endtask

    task automatic t_mask_rw();
        logic [15:0] d;
        reg_write(A_MASK, 16'hFFFF);
        reg_read(A_MASK, d); check("R2 mask all", d, 16'h007F);
        reg_write(A_MASK, 16'h0029);
        reg_read(A_MASK, d); check("R2 mask pattern", d, 16'h0029);
        reg_write(A_MASK, 16'h0000);
    endtask

    task automatic t_levels();
        logic [15:0] d;
        eng_busy = 1'b1;
        reg_read(A_STAT, d); check("R4 busy", d, 16'h1000);
        eng_rx_full = 1'b1;
        reg_write(A_STAT, 16'hFF80);
        reg_read(A_STAT, d); check("R4 busy+rxfull, ro bits", d, 16'h1800);
        eng_busy = 1'b0; eng_rx_full = 1'b0;
        reg_read(A_STAT, d); check("R4 levels low", d, 16'h0000);
    endtask

    task automatic t_masked_hold();
        logic [15:0] d;
        pulse(7'h7F);
        reg_read(A_STAT, d); check("R3 all pending masked", d, 16'h007F);
        check("R8 irq low when masked", {15'd0, irq}, 16'h0000);
        reg_read(A_VEC, d); check("R7 vector 0 when masked", d, 16'h0000);
        reg_read(A_STAT, d); check("R7 masked not cleared", d, 16'h007F);
    endtask

    task automatic t_drain();
        logic [15:0] d;
        reg_write(A_MASK, 16'h007F);
        check("R8 irq high", {15'd0, irq}, 16'h0001);
        for (int k = 1; k <= 7; k++) begin
            check("R8 irq before read", {15'd0, irq}, 16'h0001);
            reg_read(A_VEC, d); check("R6 R7 drain order", d, 16'(k));
        end
        check("R8 irq after last ack", {15'd0, irq}, 16'h0000);
        reg_read(A_VEC, d); check("R7 drained to zero", d, 16'h0000);
        reg_read(A_STAT, d); check("R7 status empty", d, 16'h0000);
    endtask

    task automatic t_priority();
        logic [15:0] d;
        pulse(7'h50);
        reg_read(A_VEC, d); check("R6 sparse first", d, 16'h0005);
        reg_read(A_VEC, d); check("R6 sparse second", d, 16'h0007);
        reg_read(A_VEC, d); check("R6 sparse done", d, 16'h0000);
        reg_write(A_MASK, 16'h003E);
        pulse(7'h09);
        reg_read(A_VEC, d); check("R6 masked top skipped", d, 16'h0004);
        reg_read(A_STAT, d); check("R7 masked top kept", d, 16'h0001);
        check("R8 irq low, only masked left", {15'd0, irq}, 16'h0000);
        reg_write(A_MASK, 16'h0001);
        check("R8 irq on unmask", {15'd0, irq}, 16'h0001);
        reg_write(A_MASK, 16'h0000);
        check("R8 irq off on mask", {15'd0, irq}, 16'h0000);
        flush();
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        reg_write(A_MASK, 16'h0000);
        pulse(7'h7F);
        reg_write(A_STAT, 16'h005B);
        reg_read(A_STAT, d); check("R5 other bits ignore w1c", d, 16'h007F);
        reg_write(A_STAT, 16'h0024);
        reg_read(A_STAT, d); check("R5 access/stop cleared", d, 16'h005B);
        flush();
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        reg_write(A_MASK, 16'h0004);
        pulse(7'h04);
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = 16'h0004; bus_wr = 1'b1; evt_pulse = 7'h04;
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0;
        reg_read(A_STAT, d); check("R9 set beats w1c", d, 16'h0004);
        @(negedge clk);
        bus_addr = A_VEC; bus_rd = 1'b1; evt_pulse = 7'h04;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; evt_pulse = '0;
        check("R9 vector code", d, 16'h0003);
        reg_read(A_STAT, d); check("R9 set beats vector ack", d, 16'h0004);
        check("R9 irq held", {15'd0, irq}, 16'h0001);
        flush();
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        reg_write(A_MASK, 16'h0012);
        reg_write(8'h0C, 16'hFFFF);
        reg_write(8'h00, 16'hFFFF);
        reg_read(8'h0C, d); check("R10 unmapped reads 0", d, 16'h0000);
        reg_read(A_MASK, d); check("R10 mask untouched", d, 16'h0012);
        pulse(7'h10);
        reg_write(8'h2C, 16'hFFFF);
        reg_read(8'h2A, d); check("R10 near-vector reads 0", d, 16'h0000);
        reg_read(A_VEC, d); check("R10 pending untouched", d, 16'h0005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_levels();
        t_masked_hold();
        t_drain();
        t_priority();
        t_w1c();
        t_set_wins();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule